// File: doc/BRIEF.md
# CPU Configuration Register Window

This block is a read-only slave that hands processor configuration words to any master on the bus. Its address window holds two 32-byte sections of eight 32-bit words each. The lower section is a generic view of the processor that is asking. The upper section holds the configuration of logical processor 0. Sections are selected by logical processor number, not by the bus port a request arrives on.

Every access is checked on privilege, direction, size, alignment and range before any data is returned. An access that breaks a rule gets an error response. A legal read by a master other than the core, aimed at the generic view, completes cleanly and returns zero.

The response is registered. Each request strobe produces exactly one ready pulse on the next cycle, and the error flag and the read data are valid together with it. The configuration contents are fixed by parameters:
- a word table and a mask of which words are mapped;
- the master ID that counts as the core;
- a presence bit for processor 0.

Top module: `cfgw_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_ready`, `rsp_error` and `rsp_rdata` are all zero.
- R2: `rsp_ready` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. `rsp_error` is never high without `rsp_ready`.
- R3: A request with `req_write` = 1 gets an error response.
- R4: A request with `req_priv` = 0 (user mode) gets an error response.
- R5: A request whose `req_size` is not 2 gets an error response. The size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved.
- R6: A request at an offset of 0x40 or above, or at an offset whose two low bits are not zero, gets an error response.
- R7: A legal read at offsets 0x00–0x1F by the master whose ID equals `CORE_MID` returns the same word as the matching offset in 0x20–0x3F.
- R8: A legal read at offsets 0x00–0x1F by any other master completes without error and returns zero.
- R9: A legal read at offset 0x20, or by the core at offset 0x00, returns the identification constant 0x434D3401 when processor 0 is present.
- R10: A legal read of word index i = offset[4:2], for i from 1 to 7, returns entry i of `CFG_WORDS` when bit i of `MAP_MASK` is set, and zero otherwise.
- R11: When `P0_PRESENT` = 0, every legal read returns zero without error. This includes the identification word.
- R12: The error rules take priority over the read-as-zero rule. For example, a write by a non-core master to offsets 0x00–0x1F gets an error.
- R13: An error response always carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_addr | input | ADDR_W (7) | Byte offset within the window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_master | input | MID_W (2) | Requesting master ID |
| rsp_ready | output | 1 | Response pulse, one cycle after `req_valid` |
| rsp_error | output | 1 | Error flag, valid with `rsp_ready` |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |

## Verification
The bench sweeps every offset in the 128-byte space against every direction, size code, privilege level and master ID. It streams the requests back to back with idle gaps, and drives the same requests into one instance with processor 0 present and one with it absent.

Each corner case is aimed at a specific mistake:
- If the generic view were decoded without looking at the master ID, non-core masters would read real configuration words instead of zero.
- If read-as-zero were applied ahead of the error rules, non-core writes or user accesses to the generic view would complete silently.
- Misaligned and out-of-window offsets catch decoders that drop the low or high address bits; such a decoder would alias those accesses onto mapped words.
- The absent-processor instance catches a design that lets the constant identification word bypass the presence gate.
- The idle gaps catch a ready signal that is held high instead of pulsed.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  // Access size codes carried on req_size.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned SECT_WORDS  = 8;
  localparam int unsigned SECT_BYTES  = WORD_BYTES * SECT_WORDS;
  localparam int unsigned NUM_SECTS   = 2;
  localparam int unsigned WIN_BYTES   = SECT_BYTES * NUM_SECTS;
  localparam int unsigned BYTE_LSB_W  = $clog2(WORD_BYTES);
  localparam int unsigned WIDX_W      = $clog2(SECT_WORDS);
  localparam int unsigned WIN_W       = $clog2(WIN_BYTES);

  // Core identification constant held in word 0 of each section.
  localparam logic [31:0] CORE_ID_WORD = 32'h434D_3401;

  // Decoded view of one request's address.
  typedef struct packed {
    logic              out_of_range;
    logic              misaligned;
    logic              generic_view;
    logic [WIDX_W-1:0] word_idx;
  } addr_dec_t;

endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_dec_t         dec
);

  localparam int unsigned SECT_BIT = WIN_W - 1;

  logic high_bits_set;

  generate
    if (ADDR_W > WIN_W) begin : g_range
      assign high_bits_set = |addr[ADDR_W-1:WIN_W];
    end else begin : g_norange
      assign high_bits_set = 1'b0;
    end
  endgenerate

  always_comb begin
    dec.out_of_range = high_bits_set;
    dec.misaligned   = |addr[BYTE_LSB_W-1:0];
    dec.generic_view = ~addr[SECT_BIT];
    dec.word_idx     = addr[BYTE_LSB_W +: WIDX_W];
  end

endmodule

// File: rtl/cfgw_policy.sv
module cfgw_policy
  import cfgw_pkg::*;
(
  input  logic      write,
  input  logic [1:0] size,
  input  logic      priv,
  input  logic      is_core,
  input  addr_dec_t dec,
  output logic      acc_err,
  output logic      acc_raz
);

  logic rule_dir, rule_priv, rule_size, rule_addr;

  always_comb begin
    rule_dir  = write;
    rule_priv = ~priv;
    rule_size = (size != SZ_WORD);
    rule_addr = dec.out_of_range | dec.misaligned;
    // Error rules dominate: read-as-zero only on otherwise legal accesses.
    acc_err   = rule_dir | rule_priv | rule_size | rule_addr;
    acc_raz   = ~acc_err & dec.generic_view & ~is_core;
  end

endmodule

// File: rtl/cfgw_store.sv
module cfgw_store
  import cfgw_pkg::*;
#(
  parameter logic [SECT_WORDS-1:0][31:0] CFG_WORDS  = '0,
  parameter logic [SECT_WORDS-1:0]       MAP_MASK   = '0,
  parameter bit                          P0_PRESENT = 1'b1
) (
  input  logic [WIDX_W-1:0] word_idx,
  output logic [31:0]       word_data
);

  logic [SECT_WORDS-1:0][31:0] table_q;

  // Build the section image once; word 0 is the fixed identification.
  generate
    for (genvar gi = 0; gi < SECT_WORDS; gi++) begin : g_word
      if (!P0_PRESENT) begin : g_absent
        assign table_q[gi] = 32'h0;
      end else if (gi == 0) begin : g_id
        assign table_q[gi] = CORE_ID_WORD;
      end else if (MAP_MASK[gi]) begin : g_mapped
        assign table_q[gi] = CFG_WORDS[gi];
      end else begin : g_hole
        assign table_q[gi] = 32'h0;
      end
    end
  endgenerate

  always_comb begin
    word_data = table_q[word_idx];
  end

endmodule

// File: rtl/cfgw_top.sv
module cfgw_top
  import cfgw_pkg::*;
#(
  parameter int unsigned                 ADDR_W     = 7,
  parameter int unsigned                 MID_W      = 2,
  parameter int unsigned                 CORE_MID   = 0,
  parameter bit                          P0_PRESENT = 1'b1,
  parameter logic [SECT_WORDS-1:0][31:0] CFG_WORDS  = {
    32'hA5A5_0007, 32'h0000_0106, 32'h0001_0005, 32'h0020_0004,
    32'h0000_0003, 32'h8000_0002, 32'h0000_0C01, 32'h0000_0000},
  parameter logic [SECT_WORDS-1:0]       MAP_MASK   = 8'b1010_0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_priv,
  input  logic [MID_W-1:0]  req_master,
  output logic              rsp_ready,
  output logic              rsp_error,
  output logic [31:0]       rsp_rdata
);

  addr_dec_t   dec;
  logic        is_core;
  logic        acc_err, acc_raz;
  logic [31:0] word_data;

  logic        ready_d, ready_q;
  logic        error_d, error_q;
  logic [31:0] rdata_d, rdata_q;
  logic        data_en;

  assign is_core = (req_master == MID_W'(CORE_MID));

  cfgw_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (req_addr),
    .dec  (dec)
  );

  cfgw_policy i_policy (
    .write   (req_write),
    .size    (req_size),
    .priv    (req_priv),
    .is_core (is_core),
    .dec     (dec),
    .acc_err (acc_err),
    .acc_raz (acc_raz)
  );

  cfgw_store #(
    .CFG_WORDS  (CFG_WORDS),
    .MAP_MASK   (MAP_MASK),
    .P0_PRESENT (P0_PRESENT)
  ) i_store (
    .word_idx  (dec.word_idx),
    .word_data (word_data)
  );

  // Next-state: response is formed from the request presented this cycle.
  always_comb begin
    ready_d = req_valid;
    error_d = req_valid & acc_err;
    rdata_d = (req_valid && !acc_err && !acc_raz) ? word_data : 32'h0;
    data_en = req_valid | ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error_q <= 1'b0;
      rdata_q <= 32'h0;
    end else if (data_en) begin
      error_q <= error_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_ready = ready_q;
  assign rsp_error = error_q;
  assign rsp_rdata = rdata_q;

  logic legal_read;
  assign legal_read = req_valid && req_priv && !req_write && (req_size == SZ_WORD)
                      && (req_addr[1:0] == 2'b00) && (req_addr < ADDR_W'(WIN_BYTES));

  AST_READY_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);  // R2
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);  // R2
  AST_ERROR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_ready);  // R2
  AST_WRITE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_error);  // R3
  AST_USER_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv) |=> rsp_error);  // R4
  AST_SIZE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_WORD) |=> rsp_error);  // R5
  AST_GENERIC_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_read && !req_addr[5] && req_master != MID_W'(CORE_MID))
      |=> (!rsp_error && rsp_rdata == 32'h0));  // R8
  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (P0_PRESENT && legal_read && req_addr == ADDR_W'(32)) |=> (rsp_rdata == CORE_ID_WORD));  // R9
  AST_ERROR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_rdata == 32'h0));  // R13

endmodule

// File: tb/test_cfgw_top.sv
`timescale 1ns/100ps
module test_cfgw_top;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned MID_W  = 2;
  localparam int unsigned CORE   = 1;
  localparam logic [31:0] ID     = 32'h434D_3401;
  localparam logic [7:0][31:0] TBW = {
    32'h1111_7007, 32'h2222_6006, 32'h3333_5005, 32'h4444_4004,
    32'h5555_3003, 32'h6666_2002, 32'h7777_1001, 32'hDEAD_BEEF};
  localparam logic [7:0] TBM = 8'b1010_0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic req_priv = 1'b0;
  logic [MID_W-1:0] req_master = '0;
  logic rdy_a, err_a, rdy_b, err_b;
  logic [31:0] dat_a, dat_b;

  always #2.5 clk = ~clk;

  cfgw_top #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CORE_MID(CORE), .P0_PRESENT(1'b1),
             .CFG_WORDS(TBW), .MAP_MASK(TBM)) i_cfgw_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
    .req_master(req_master), .rsp_ready(rdy_a), .rsp_error(err_a), .rsp_rdata(dat_a));

  cfgw_top #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CORE_MID(CORE), .P0_PRESENT(1'b0),
             .CFG_WORDS(TBW), .MAP_MASK(TBM)) i_cfgw_top_absent (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
    .req_master(req_master), .rsp_ready(rdy_b), .rsp_error(err_b), .rsp_rdata(dat_b));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Pending expectation from the previous cycle's request.
  logic       p_valid = 1'b0;
  logic       p_err_a, p_err_b;
  logic [31:0] p_dat_a, p_dat_b;
  string      p_tag_a, p_tag_b;

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual rdy/err/data=%0b/%0b/%h expected %0b/%0b/%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  function automatic void expect_rsp(input logic [ADDR_W-1:0] a, input logic wr,
      input logic [1:0] sz, input logic pr, input logic [MID_W-1:0] m, input bit present,
      output logic e, output logic [31:0] d, output string tag);
    bit generic = (a < 32);
    bit core = (m == MID_W'(CORE));
    int w = (a % 32) / 4;
    e = wr || !pr || sz != 2'd2 || a >= 64 || a[1:0] != 2'b00;
    d = 32'h0;
    if (e) begin
      if (generic && !core && a[1:0] == 0) tag = "R12";
      else if (wr) tag = "R3";
      else if (!pr) tag = "R4";
      else if (sz != 2'd2) tag = "R5";
      else tag = "R6";
    end else if (generic && !core) begin
      tag = "R8";
    end else if (!present) begin
      tag = "R11";
    end else begin
      if (w == 0) begin d = ID; tag = generic ? "R7" : "R9"; end
      else begin d = TBM[w] ? TBW[w] : 32'h0; tag = generic ? "R7" : "R10"; end
    end
  endfunction

  task automatic step(input logic v, input logic [ADDR_W-1:0] a, input logic wr,
                      input logic [1:0] sz, input logic pr, input logic [MID_W-1:0] m);
    @(negedge clk);
    if (p_valid) begin
      check({p_tag_a, " R13"}, {rdy_a, err_a, dat_a}, {1'b1, p_err_a, p_dat_a});
      check({p_tag_b, " absent"}, {rdy_b, err_b, dat_b}, {1'b1, p_err_b, p_dat_b});
    end else begin
      check("R2 idle", {rdy_a, err_a, 32'h0}, 34'h0);
      check("R2 idle absent", {rdy_b, err_b, 32'h0}, 34'h0);
    end
    req_valid = v; req_addr = a; req_write = wr; req_size = sz;
    req_priv = pr; req_master = m;
    p_valid = v;
    if (v) begin
      expect_rsp(a, wr, sz, pr, m, 1'b1, p_err_a, p_dat_a, p_tag_a);
      expect_rsp(a, wr, sz, pr, m, 1'b0, p_err_b, p_dat_b, p_tag_b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {rdy_a, err_a, dat_a}, 34'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {rdy_a, err_a, dat_a}, 34'h0);
    for (int a = 0; a < 128; a++) begin
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 4; sz++)
          for (int pr = 0; pr < 2; pr++)
            for (int m = 0; m < 4; m++)
              step(1'b1, ADDR_W'(a), wr[0], sz[1:0], pr[0], m[1:0]);
      step(1'b0, '0, 1'b0, 2'd0, 1'b0, '0);
      step(1'b0, '0, 1'b0, 2'd0, 1'b0, '0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R2 actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule